// File: doc/BRIEF.md
# Scaled Effective Address Generator

This block forms the effective address of a memory operand from a small internal register file, a packed operand-format byte and a displacement field. The address is the sum of an optional base register, an optional index register shifted by a scale factor, and a sign-extended displacement. Each caller supplies the format byte, two enables that say whether the base and index terms are used, a displacement-length select and the displacement bits. The block presents the sum as a registered address with a valid strobe one clock later.

Two address modes are supported. The wide mode produces a 32-bit address, takes an 8-bit or a 32-bit displacement, and scales the index by 1, 2, 4 or 8. The narrow mode works on 16-bit quantities, takes an 8-bit or a 16-bit displacement, and never scales. A narrow request whose format byte carries a nonzero scale code is flagged as illegal. The eight register values are loaded through a single write port.

Top module: `eag_top`

## Requirements
- R1: While reset is high and on the first cycle after it, `out_valid`, `ea` and `bad_fmt` are all zero.
- R2: A write with `rf_we` high stores `rf_wdata` into entry `rf_waddr` at the clock edge. An address computed in the same cycle as a write to a register it reads uses the value the register held before that write.
- R3: Within `fmt`, bits [7:6] are the scale code, bits [5:3] are the index register number and bits [2:0] are the base register number.
- R4: When `use_base` is low the base term is zero. When `use_index` is low the index term is zero, whatever register numbers `fmt` names.
- R5: In wide mode (`wide_mode`=1) the index term is the index register shifted left by the scale code, so codes 0, 1, 2 and 3 scale by 1, 2, 4 and 8.
- R6: In wide mode, `disp_long`=0 uses `disp[7:0]` sign-extended to 32 bits, and `disp_long`=1 uses all 32 bits of `disp`.
- R7: In narrow mode (`wide_mode`=0), `disp_long`=0 uses `disp[7:0]` sign-extended, and `disp_long`=1 uses `disp[15:0]` sign-extended. `disp[31:16]` has no effect.
- R8: In narrow mode only the low 16 bits of each register take part. The result wraps modulo 2^16 and `ea[31:16]` is zero.
- R9: In narrow mode the scale is always 1. `bad_fmt` is high together with `out_valid` exactly when a narrow request had a nonzero scale code. `bad_fmt` is low on every other cycle.
- R10: `out_valid` is high on the cycle after `in_valid` was high and low otherwise. `ea` keeps its last value while no request is accepted.
- R11: In wide mode the sum wraps modulo 2^32.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rf_we | input | 1 | Register file write enable |
| rf_waddr | input | 3 | Register number to write |
| rf_wdata | input | 32 | Value to write |
| in_valid | input | 1 | Address request strobe |
| wide_mode | input | 1 | 1 selects 32-bit mode, 0 selects 16-bit mode |
| fmt | input | 8 | Packed scale code, index number and base number |
| use_base | input | 1 | Base register term is used |
| use_index | input | 1 | Index register term is used |
| disp_long | input | 1 | 0 selects an 8-bit displacement, 1 selects the long displacement |
| disp | input | 32 | Displacement bits |
| out_valid | output | 1 | Registered result valid |
| ea | output | 32 | Registered effective address |
| bad_fmt | output | 1 | Narrow request had a nonzero scale code |

## Verification
Two functions can fall in the same cycle: a register-file write and an address request that reads the same register. The bench provokes this on purpose, with directed cases and again during a long stretch of random traffic that draws writes and requests together. A behavioural model computes each expected address from its copy of the registers before it applies that cycle's write. Any forwarding of the new value, or a lost write, therefore shows up as an address mismatch on the following cycle.

// File: rtl/eag_pkg.sv
package eag_pkg;
  localparam int SCALE_W = 2;
  localparam int RNUM_W  = 3;

  typedef struct packed {
    logic [SCALE_W-1:0] scale;
    logic [RNUM_W-1:0]  idx;
    logic [RNUM_W-1:0]  base;
  } opfmt_t;
endpackage

// File: rtl/eag_regfile.sv
module eag_regfile #(
  parameter int W     = 32,
  parameter int DEPTH = 8,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [W-1:0]  wdata,
  input  logic [AW-1:0] ra0,
  output logic [W-1:0]  rd0,
  input  logic [AW-1:0] ra1,
  output logic [W-1:0]  rd1
);
  logic [W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  assign rd0 = mem[ra0];
  assign rd1 = mem[ra1];

  // R2: a write lands in the addressed entry at the edge
  assert_write_lands_R2: assert property (@(posedge clk) disable iff (rst)
    we |=> mem[$past(waddr)] == $past(wdata));
endmodule

// File: rtl/eag_disp_ext.sv
module eag_disp_ext #(
  parameter int ADDR_W   = 32,
  parameter int NARROW_W = 16,
  parameter int SHORT_W  = 8
) (
  input  logic              wide,
  input  logic              long_sel,
  input  logic [ADDR_W-1:0] disp_in,
  output logic [ADDR_W-1:0] disp_out
);
  always_comb begin
    if (!long_sel)
      disp_out = {{(ADDR_W-SHORT_W){disp_in[SHORT_W-1]}}, disp_in[SHORT_W-1:0]};
    else if (wide)
      disp_out = disp_in;
    else
      disp_out = {{(ADDR_W-NARROW_W){disp_in[NARROW_W-1]}}, disp_in[NARROW_W-1:0]};
  end

  // R6/R7: a short displacement always carries its sign into the upper bits
  always_comb begin
    if (!long_sel)
      assert_short_sign_R6: assert (disp_out[ADDR_W-1] == disp_in[SHORT_W-1]);
  end
endmodule

// File: rtl/eag_scaler.sv
module eag_scaler #(
  parameter int ADDR_W  = 32,
  parameter int SCALE_W = 2
) (
  input  logic [ADDR_W-1:0]  idx_val,
  input  logic [SCALE_W-1:0] shamt,
  output logic [ADDR_W-1:0]  scaled
);
  assign scaled = idx_val << shamt;

  // R5: the bits below the shift amount are cleared
  always_comb begin
    assert_low_bits_clear_R5: assert ((scaled & ((ADDR_W'(1) << shamt) - ADDR_W'(1))) == '0);
  end
endmodule

// File: rtl/eag_top.sv
module eag_top #(
  parameter int ADDR_W   = 32,
  parameter int NARROW_W = 16,
  parameter int NREGS    = 8,
  localparam int RA_W    = $clog2(NREGS)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rf_we,
  input  logic [RA_W-1:0]   rf_waddr,
  input  logic [ADDR_W-1:0] rf_wdata,
  input  logic              in_valid,
  input  logic              wide_mode,
  input  logic [7:0]        fmt,
  input  logic              use_base,
  input  logic              use_index,
  input  logic              disp_long,
  input  logic [ADDR_W-1:0] disp,
  output logic              out_valid,
  output logic [ADDR_W-1:0] ea,
  output logic              bad_fmt
);
  import eag_pkg::*;

  localparam logic [ADDR_W-1:0] NMASK = {{(ADDR_W-NARROW_W){1'b0}}, {NARROW_W{1'b1}}};

  opfmt_t              f;
  logic [ADDR_W-1:0]   base_rd, idx_rd, base_t, idx_t, scaled, disp_x, sum, ea_next;
  logic [SCALE_W-1:0]  shamt;
  logic                mode_q;

  assign f = opfmt_t'(fmt);

  eag_regfile #(.W(ADDR_W), .DEPTH(NREGS)) u_rf (
    .clk(clk), .rst(rst), .we(rf_we), .waddr(rf_waddr), .wdata(rf_wdata),
    .ra0(f.base), .rd0(base_rd), .ra1(f.idx), .rd1(idx_rd)
  );

  always_comb begin
    base_t = use_base  ? base_rd : '0;
    idx_t  = use_index ? idx_rd  : '0;
    if (!wide_mode) begin
      base_t = base_t & NMASK;
      idx_t  = idx_t  & NMASK;
    end
    shamt = wide_mode ? f.scale : '0;
  end

  eag_scaler #(.ADDR_W(ADDR_W), .SCALE_W(SCALE_W)) u_scl (
    .idx_val(idx_t), .shamt(shamt), .scaled(scaled)
  );

  eag_disp_ext #(.ADDR_W(ADDR_W), .NARROW_W(NARROW_W), .SHORT_W(8)) u_dx (
    .wide(wide_mode), .long_sel(disp_long), .disp_in(disp), .disp_out(disp_x)
  );

  assign sum     = base_t + scaled + disp_x;
  assign ea_next = wide_mode ? sum : (sum & NMASK);

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      ea        <= '0;
      bad_fmt   <= 1'b0;
      mode_q    <= 1'b1;
    end else begin
      out_valid <= in_valid;
      bad_fmt   <= in_valid && !wide_mode && (f.scale != '0);
      if (in_valid) begin
        ea     <= ea_next;
        mode_q <= wide_mode;
      end
    end
  end

  // R10: one-cycle latency of the strobe
  assert_valid_follows_R10: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_valid);
  assert_valid_quiet_R10: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> !out_valid);
  // R10: address holds while idle
  assert_ea_hold_R10: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> $stable(ea));
  // R8: a narrow result never sets upper bits
  assert_narrow_upper_R8: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !mode_q) |-> (ea & ~NMASK) == '0);
  // R9: the illegal flag only accompanies a valid narrow result
  assert_bad_narrow_R9: assert property (@(posedge clk) disable iff (rst)
    bad_fmt |-> (out_valid && !mode_q));
  assert_bad_cause_R9: assert property (@(posedge clk) disable iff (rst)
    (in_valid && wide_mode) |=> !bad_fmt);
endmodule

// File: tb/eag_top_bench.sv
`timescale 1ns/1ps
module eag_top_bench;
  logic        clk = 1'b0;
  logic        rst;
  logic        rf_we;
  logic [2:0]  rf_waddr;
  logic [31:0] rf_wdata;
  logic        in_valid, wide_mode, use_base, use_index, disp_long;
  logic [7:0]  fmt;
  logic [31:0] disp;
  logic        out_valid, bad_fmt;
  logic [31:0] ea;

  int checks = 0;
  int fails  = 0;
  bit finished = 0;

  logic [31:0] mrf [8];
  logic [31:0] exp_ea = '0;

  always #2 clk = ~clk;

  eag_top u_eag_top (
    .clk(clk), .rst(rst), .rf_we(rf_we), .rf_waddr(rf_waddr), .rf_wdata(rf_wdata),
    .in_valid(in_valid), .wide_mode(wide_mode), .fmt(fmt), .use_base(use_base),
    .use_index(use_index), .disp_long(disp_long), .disp(disp),
    .out_valid(out_valid), .ea(ea), .bad_fmt(bad_fmt)
  );

  task automatic chk(string tag, logic [31:0] got, logic [31:0] want);
    checks++;
    if (got !== want) begin
      fails++;
      $display("FAIL %s: got %h expected %h", tag, got, want);
    end
  endtask

  function automatic logic [31:0] model(bit wide, logic [7:0] f, bit ub, bit ui,
                                        bit dl, logic [31:0] d);
    longint b, i, dv, r;
    int sc, bn, xn;
    sc = int'(f) / 64;
    xn = (int'(f) / 8) % 8;
    bn = int'(f) % 8;
    b = ub ? longint'(mrf[bn]) : 0;
    i = ui ? longint'(mrf[xn]) : 0;
    dv = longint'(d[7:0]);
    if (dv >= 128) dv -= 256;
    if (wide) begin
      if (dl) dv = longint'(d);
      r = (b + i * (2 ** sc) + dv) % 64'h1_0000_0000;
      if (r < 0) r += 64'h1_0000_0000;
    end else begin
      b = b % 65536;
      i = i % 65536;
      if (dl) begin
        dv = longint'(d[15:0]);
        if (dv >= 32768) dv -= 65536;
      end
      r = (b + i + dv) % 65536;
      if (r < 0) r += 65536;
    end
    return r[31:0];
  endfunction

  task automatic step(string tag, bit we, int wa, logic [31:0] wd, bit iv, bit wide,
                      logic [7:0] f, bit ub, bit ui, bit dl, logic [31:0] d);
    bit exp_bad;
    rf_we = we; rf_waddr = wa[2:0]; rf_wdata = wd;
    in_valid = iv; wide_mode = wide; fmt = f; use_base = ub; use_index = ui;
    disp_long = dl; disp = d;
    exp_bad = iv && !wide && (f[7:6] != 2'b00);
    if (iv) exp_ea = model(wide, f, ub, ui, dl, d);
    @(posedge clk);
    #1;
    if (we) mrf[wa] = wd;
    chk({tag, " valid (R10)"}, {31'b0, out_valid}, {31'b0, iv});
    chk({tag, " ea"}, ea, exp_ea);
    chk({tag, " bad_fmt (R9)"}, {31'b0, bad_fmt}, {31'b0, exp_bad});
  endtask

  task automatic idle(string tag);
    step(tag, 0, 0, 0, 0, 1, 8'h00, 0, 0, 0, 0);
  endtask

  initial begin
    #(4 * 150000);
    if (!finished) begin
      fails++;
      checks++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    rst = 1'b1; rf_we = 0; rf_waddr = 0; rf_wdata = 0; in_valid = 0; wide_mode = 1;
    fmt = 0; use_base = 0; use_index = 0; disp_long = 0; disp = 0;
    repeat (3) @(posedge clk);
    #1;
    chk("R1 reset out_valid", {31'b0, out_valid}, 0);
    chk("R1 reset ea", ea, 0);
    chk("R1 reset bad_fmt", {31'b0, bad_fmt}, 0);
    rst = 1'b0;
    @(posedge clk);
    #1;
    chk("R1 after reset out_valid", {31'b0, out_valid}, 0);
    chk("R1 after reset ea", ea, 0);

    // R2: load the register file
    for (int k = 0; k < 8; k++)
      step("R2 load", 1, k, 32'h0010_0100 * (k + 1) + 32'h0000_8003, 0, 1, 8'h00, 0, 0, 0, 0);
    step("R2 load r7", 1, 7, 32'hFFFF_FFF0, 0, 1, 8'h00, 0, 0, 0, 0);

    // R3/R5: every scale code, base r1 index r2, fields at [7:6],[5:3],[2:0]
    for (int s = 0; s < 4; s++)
      step("R3 R5 scale", 0, 0, 0, 1, 1, {s[1:0], 3'd2, 3'd1}, 1, 1, 0, 32'h0000_0010);
    // R6: negative short and full long displacement
    step("R6 short neg", 0, 0, 0, 1, 1, {2'd1, 3'd3, 3'd4}, 1, 1, 0, 32'h1234_56F0);
    step("R6 long", 0, 0, 0, 1, 1, {2'd3, 3'd5, 3'd6}, 1, 1, 1, 32'h8000_0004);
    // R4: absent terms
    step("R4 no base", 0, 0, 0, 1, 1, {2'd2, 3'd3, 3'd7}, 0, 1, 0, 32'h0000_0001);
    step("R4 no index", 0, 0, 0, 1, 1, {2'd2, 3'd3, 3'd7}, 1, 0, 0, 32'h0000_0001);
    step("R4 neither", 0, 0, 0, 1, 1, {2'd3, 3'd6, 3'd5}, 0, 0, 1, 32'hCAFE_0001);
    // R11: wide wrap
    step("R11 wrap", 0, 0, 0, 1, 1, {2'd3, 3'd7, 3'd7}, 1, 1, 1, 32'h0000_0100);
    // R7: narrow long displacement, upper bits ignored
    step("R7 narrow long", 0, 0, 0, 1, 0, {2'd0, 3'd2, 3'd1}, 1, 1, 1, 32'hABCD_FF00);
    step("R7 narrow short", 0, 0, 0, 1, 0, {2'd0, 3'd2, 3'd1}, 1, 1, 0, 32'h5555_5580);
    // R8: narrow wrap
    step("R8 narrow wrap", 0, 0, 0, 1, 0, {2'd0, 3'd7, 3'd7}, 1, 1, 1, 32'h0000_7FFF);
    // R9: nonzero scale in narrow is flagged, scale not applied
    step("R9 narrow bad", 0, 0, 0, 1, 0, {2'd2, 3'd3, 3'd1}, 1, 1, 0, 32'h0000_0002);
    // R10: idle holds the address
    idle("R10 hold");
    idle("R10 hold2");
    // R2: write and read of the same register in one cycle
    step("R2 same cycle", 1, 1, 32'h0000_0500, 1, 1, {2'd1, 3'd1, 3'd1}, 1, 1, 0, 0);
    step("R2 after write", 0, 0, 0, 1, 1, {2'd1, 3'd1, 3'd1}, 1, 1, 0, 0);

    // mixed random traffic with overlapping writes
    for (int n = 0; n < 2000; n++) begin
      logic [31:0] rv;
      rv = $urandom;
      step("R2 R5 R8 random", rv[0], int'(rv[3:1]), $urandom, rv[4] | rv[5], rv[6],
           rv[15:8], rv[16], rv[17], rv[18], $urandom);
    end
    idle("R10 end");

    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule